// File: doc/BRIEF.md
# Message Handler Fault Status Register

This block is the fault and progress status word that a communication controller's message handler shows to its host. It holds three 7-bit buffer indices: the buffer most recently updated, the buffer most recently transmitted with success, and the first buffer found holding uncorrectable data. It also keeps sticky error flags for five data paths and a busy indication for a clear-all-RAMs command. The message handler, the RAM-clear sequencer and the controller state machine drive it only through single-cycle event strobes.

The host reads the composed 32-bit word combinationally. It clears flags by writing ones to byte lane 0 under a synchronous write enable. The faulty-buffer index locks at the first uncorrectable error. Later errors only raise a second flag until the host acknowledges the first. The two progress indices return to zero when the controller leaves configuration or enters startup.

Top module: `mh_fault_status`

## Requirements
- R1: After a synchronous active-low reset the read word is 0x0000_0080: every index and flag is 0 except the clear-RAMs busy bit 7.
- R2: A pulse on `upd_valid` loads `upd_idx` into bits 30:24. A pulse on `tx_valid` loads `tx_idx` into bits 22:16. Both values are visible on the cycle after the pulse.
- R3: A pulse on `cfg_exit` or `startup_enter` sets bits 30:24 and 22:16 to 0. When an update or transmit pulse arrives in the same cycle, that field loads the new index instead.
- R4: Bits 31, 23 and 15 always read 0. Host writes never change bits 30:8, whatever the data or byte strobes.
- R5: A `fault_valid` pulse while bit 5 is 0 loads `fault_idx` into bits 14:8 and sets bit 5. While bit 5 is 1, bits 14:8 do not change.
- R6: A `fault_valid` pulse while bit 5 is already 1 sets bit 6.
- R7: With `host_we` high and `host_be[0]` high, a 1 in `host_wdata` bit 6, 5, 4, 3, 2 or 0 clears that flag. A 0 in the data, or `host_be[0]` low, leaves the flag unchanged.
- R8: When an event that sets a flag and a host clear of that flag fall in the same cycle, the flag reads 1 afterwards.
- R9: Bit 7 is set by `clr_ram_start` and cleared by `clr_ram_done`. Start wins when both pulse in the same cycle. Host writes do not change bit 7.
- R10: Bit 1 is set by `obuf_err` and host writes do not clear it. Only reset clears it.
- R11: `tbufb_err` sets bit 4, `tbufa_err` sets bit 3, `pread_err` sets bit 2 and `ibuf_err` sets bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write enable, one cycle per write |
| host_be | input | 4 | Host byte strobes; only lane 0 carries clear bits |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Composed status word |
| upd_valid | input | 1 | Buffer-updated event |
| upd_idx | input | 7 | Index of the updated buffer |
| tx_valid | input | 1 | Buffer-transmitted event |
| tx_idx | input | 7 | Index of the transmitted buffer |
| fault_valid | input | 1 | Uncorrectable-error event on a buffer |
| fault_idx | input | 7 | Index of the faulty buffer |
| cfg_exit | input | 1 | Controller leaves configuration state |
| startup_enter | input | 1 | Controller enters startup state |
| tbufb_err | input | 1 | Uncorrectable error reading transient RAM B |
| tbufa_err | input | 1 | Uncorrectable error reading transient RAM A |
| pread_err | input | 1 | Partial-read path error |
| obuf_err | input | 1 | Output-buffer path error |
| ibuf_err | input | 1 | Input-buffer path error |
| clr_ram_start | input | 1 | Clear-all-RAMs command issued |
| clr_ram_done | input | 1 | RAM-clear sequencer finished |

## Verification
The assertions treat every event input as a level sampled on the rising edge. They assume these inputs carry no X after reset and that a pulse lasting several cycles acts as repeated events. The stimulus drives all strobes as single-cycle pulses set up on the falling edge and returns them to 0 after each cycle. A behavioural model advances alongside the design, and every field is compared on every cycle. The done pulse comes from a short counter a few cycles after each start, as the sequencer would send it. Same-cycle collisions (event with clear, start with done, update with state change) are created on purpose.

// File: rtl/mhfs_pkg.sv
// Package: shared widths and bit positions of the message handler
// fault status word. Positions are fixed because host software decodes them.
package mhfs_pkg;
    localparam int IDX_W     = 7;
    localparam int WORD_W    = 32;
    localparam int UPD_LSB   = 24;
    localparam int TX_LSB    = 16;
    localparam int FMB_LSB   = 8;
    localparam int BIT_BUSY  = 7;
    localparam int BIT_MULTI = 6;
    localparam int BIT_DET   = 5;
    localparam int BIT_TBB   = 4;
    localparam int BIT_TBA   = 3;
    localparam int BIT_PRD   = 2;
    localparam int BIT_OBF   = 1;
    localparam int BIT_IBF   = 0;
    localparam int NUM_PATH  = 5;
endpackage

// File: rtl/mhfs_index_reg.sv
// Module: mhfs_index_reg
// Holds one buffer index. A load pulse captures a new value. A zero pulse
// returns it to 0, and a load in the same cycle takes priority.
// Assumes load and zero are single-cycle strobes synchronous to clk.
module mhfs_index_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         zero,
    output logic [W-1:0] q
);
    // Purpose: capture or clear the index, load first.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (zero) q <= '0;
    end

    AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> (q == '0)); // R3
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val))); // R2
endmodule

// File: rtl/mhfs_fault_capture.sv
// Module: mhfs_fault_capture
// Captures the first faulty buffer index and a detect flag. Later faults
// while detect is set raise the multi flag and leave the index locked.
// Host clears (write-1) lose to a same-cycle fault event.
// Assumes fault_valid is a one-cycle event strobe.
module mhfs_fault_capture #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fault_valid,
    input  logic [W-1:0] fault_idx,
    input  logic         clr_detect,
    input  logic         clr_multi,
    output logic [W-1:0] idx_q,
    output logic         detect_q,
    output logic         multi_q
);
    logic first_hit;
    logic repeat_hit;

    // Purpose: split a fault event by whether the index is already locked.
    always_comb begin
        first_hit  = fault_valid && !detect_q;
        repeat_hit = fault_valid &&  detect_q;
    end

    // Purpose: load the index only on the first fault.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx_q <= '0;
        else if (first_hit) idx_q <= fault_idx;
    end

    // Purpose: detect flag, set by any fault, cleared by host write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)           detect_q <= 1'b0;
        else if (fault_valid) detect_q <= 1'b1;
        else if (clr_detect)  detect_q <= 1'b0;
    end

    // Purpose: multi flag, set by a fault while locked.
    always_ff @(posedge clk) begin
        if (!rst_n)          multi_q <= 1'b0;
        else if (repeat_hit) multi_q <= 1'b1;
        else if (clr_multi)  multi_q <= 1'b0;
    end

    AST_FMB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        detect_q |=> $stable(idx_q)); // R5
    AST_FMB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !detect_q) |=> (detect_q && idx_q == $past(fault_idx))); // R5
    AST_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && detect_q) |=> multi_q); // R6
    AST_DET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && clr_detect) |=> detect_q); // R8
endmodule

// File: rtl/mhfs_flag_bank.sv
// Module: mhfs_flag_bank
// A row of sticky error flags. Each is set by its event and cleared by a
// host write-1 when its bit in CLR_MASK is 1. The event wins a collision.
// Assumes ev and clr are one-cycle strobes.
module mhfs_flag_bank #(
    parameter int          N        = 5,
    parameter logic [N-1:0] CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        if (CLR_MASK[i]) begin : g_clearable
            // Purpose: sticky flag with host write-1 clear.
            always_ff @(posedge clk) begin
                if (!rst_n)      flags[i] <= 1'b0;
                else if (ev[i])  flags[i] <= 1'b1;
                else if (clr[i]) flags[i] <= 1'b0;
            end
        end else begin : g_readonly
            // Purpose: sticky flag that only reset clears.
            always_ff @(posedge clk) begin
                if (!rst_n)     flags[i] <= 1'b0;
                else if (ev[i]) flags[i] <= 1'b1;
            end
            AST_RO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                flags[i] |=> flags[i]); // R10
        end
        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flags[i]); // R8
        AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev[i] && !clr[i]) |=> $stable(flags[i])); // R7
    end
endmodule

// File: rtl/mh_fault_status.sv
// Module: mh_fault_status
// Top of the message handler fault status register. Composes three buffer
// indices, the fault capture, the sticky path flags and the clear-RAMs busy
// bit into one 32-bit word read combinationally by the host.
// Assumes all event inputs are synchronous one-cycle strobes.
module mh_fault_status
    import mhfs_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [3:0]    host_be,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          upd_valid,
    input  logic [IW-1:0] upd_idx,
    input  logic          tx_valid,
    input  logic [IW-1:0] tx_idx,
    input  logic          fault_valid,
    input  logic [IW-1:0] fault_idx,
    input  logic          cfg_exit,
    input  logic          startup_enter,
    input  logic          tbufb_err,
    input  logic          tbufa_err,
    input  logic          pread_err,
    input  logic          obuf_err,
    input  logic          ibuf_err,
    input  logic          clr_ram_start,
    input  logic          clr_ram_done
);
    localparam logic [NUM_PATH-1:0] PATH_CLR_MASK = 5'b11101;

    logic [7:0]          w1c;
    logic                state_zero;
    logic [IW-1:0]       upd_q, tx_q, fmb_q;
    logic                det_q, multi_q, busy_q;
    logic [NUM_PATH-1:0] path_ev, path_clr, path_q;
    logic                unused_wdata;

    // Purpose: decode the write-1-clear mask from byte lane 0.
    always_comb begin
        w1c        = (host_we && host_be[0]) ? host_wdata[7:0] : 8'h00;
        state_zero = cfg_exit || startup_enter;
    end
    assign unused_wdata = ^{host_wdata[31:8], host_be[3:1]};

    mhfs_index_reg #(.W(IW)) u_upd (
        .clk(clk), .rst_n(rst_n), .load(upd_valid), .load_val(upd_idx),
        .zero(state_zero), .q(upd_q));

    mhfs_index_reg #(.W(IW)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_valid), .load_val(tx_idx),
        .zero(state_zero), .q(tx_q));

    mhfs_fault_capture #(.W(IW)) u_fault (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid),
        .fault_idx(fault_idx), .clr_detect(w1c[BIT_DET]),
        .clr_multi(w1c[BIT_MULTI]), .idx_q(fmb_q), .detect_q(det_q),
        .multi_q(multi_q));

    // Purpose: order path events and clears to match bits 4:0.
    always_comb begin
        path_ev  = {tbufb_err, tbufa_err, pread_err, obuf_err, ibuf_err};
        path_clr = w1c[NUM_PATH-1:0];
    end

    mhfs_flag_bank #(.N(NUM_PATH), .CLR_MASK(PATH_CLR_MASK)) u_paths (
        .clk(clk), .rst_n(rst_n), .ev(path_ev), .clr(path_clr), .flags(path_q));

    // Purpose: clear-RAMs busy bit, set by reset and start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)             busy_q <= 1'b1;
        else if (clr_ram_start) busy_q <= 1'b1;
        else if (clr_ram_done)  busy_q <= 1'b0;
    end

    // Purpose: compose the read word with zero reserved bits.
    always_comb begin
        host_rdata = '0;
        host_rdata[UPD_LSB +: IW] = upd_q;
        host_rdata[TX_LSB  +: IW] = tx_q;
        host_rdata[FMB_LSB +: IW] = fmb_q;
        host_rdata[BIT_BUSY]      = busy_q;
        host_rdata[BIT_MULTI]     = multi_q;
        host_rdata[BIT_DET]       = det_q;
        host_rdata[NUM_PATH-1:0]  = path_q;
    end

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ram_start |=> host_rdata[BIT_BUSY]); // R9
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ram_done && !clr_ram_start) |=> !host_rdata[BIT_BUSY]); // R9
    AST_HOST_NO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !upd_valid && !tx_valid && !fault_valid && !state_zero)
        |=> $stable(host_rdata[30:8])); // R4

    // Purpose: reserved bits stay zero.
    always_comb begin
        if (rst_n) begin
            AST_RSVD_ZERO: assert ({host_rdata[31], host_rdata[23], host_rdata[15]} == 3'b000); // R4
        end
    end
endmodule

// File: tb/sim_mh_fault_status.sv
// Bench: behavioural model stepped every clock, all fields compared at the
// falling edge after each rising edge.
module sim_mh_fault_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 0;
    logic [3:0]  host_be = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        upd_valid = 0, tx_valid = 0, fault_valid = 0;
    logic [6:0]  upd_idx = 0, tx_idx = 0, fault_idx = 0;
    logic        cfg_exit = 0, startup_enter = 0;
    logic        tbufb_err = 0, tbufa_err = 0, pread_err = 0, obuf_err = 0, ibuf_err = 0;
    logic        clr_ram_start = 0, clr_ram_done = 0;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    // model state
    int m_upd, m_tx, m_fmb;
    bit m_busy, m_multi, m_det, m_tbb, m_tba, m_prd, m_obf, m_ibf;

    always #10 clk = ~clk;

    mh_fault_status u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .tx_valid(tx_valid),
        .tx_idx(tx_idx), .fault_valid(fault_valid), .fault_idx(fault_idx),
        .cfg_exit(cfg_exit), .startup_enter(startup_enter),
        .tbufb_err(tbufb_err), .tbufa_err(tbufa_err), .pread_err(pread_err),
        .obuf_err(obuf_err), .ibuf_err(ibuf_err),
        .clr_ram_start(clr_ram_start), .clr_ram_done(clr_ram_done));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit [7:0] c;
        bit old_det;
        if (!rst_n) begin
            m_upd = 0; m_tx = 0; m_fmb = 0;
            m_busy = 1; m_multi = 0; m_det = 0;
            m_tbb = 0; m_tba = 0; m_prd = 0; m_obf = 0; m_ibf = 0;
            return;
        end
        c = (host_we && host_be[0]) ? host_wdata[7:0] : 8'h00;
        if (upd_valid) m_upd = upd_idx; else if (cfg_exit || startup_enter) m_upd = 0;
        if (tx_valid) m_tx = tx_idx; else if (cfg_exit || startup_enter) m_tx = 0;
        old_det = m_det;
        if (fault_valid && !old_det) m_fmb = fault_idx;
        m_multi = (fault_valid && old_det) ? 1'b1 : (m_multi && !c[6]);
        m_det   = fault_valid ? 1'b1 : (m_det && !c[5]);
        m_tbb = tbufb_err ? 1'b1 : (m_tbb && !c[4]);
        m_tba = tbufa_err ? 1'b1 : (m_tba && !c[3]);
        m_prd = pread_err ? 1'b1 : (m_prd && !c[2]);
        m_obf = obuf_err  ? 1'b1 : m_obf;
        m_ibf = ibuf_err  ? 1'b1 : (m_ibf && !c[0]);
        m_busy = clr_ram_start ? 1'b1 : (clr_ram_done ? 1'b0 : m_busy);
    endtask

    task automatic compare_all();
        chk("R2 R3 updated index", int'(host_rdata[30:24]), m_upd);
        chk("R2 R3 transmitted index", int'(host_rdata[22:16]), m_tx);
        chk("R4 reserved bits", int'({host_rdata[31], host_rdata[23], host_rdata[15]}), 0);
        chk("R5 faulty index", int'(host_rdata[14:8]), m_fmb);
        chk("R5 R7 detect flag", int'(host_rdata[5]), int'(m_det));
        chk("R6 R7 multi flag", int'(host_rdata[6]), int'(m_multi));
        chk("R9 busy bit", int'(host_rdata[7]), int'(m_busy));
        chk("R10 output-buffer flag", int'(host_rdata[1]), int'(m_obf));
        chk("R11 R7 path flags 4,3,2,0",
            int'({host_rdata[4], host_rdata[3], host_rdata[2], host_rdata[0]}),
            int'({m_tbb, m_tba, m_prd, m_ibf}));
    endtask

    // one clock: inputs already set at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        host_we = 0; host_be = 0; host_wdata = 0;
        upd_valid = 0; tx_valid = 0; fault_valid = 0;
        cfg_exit = 0; startup_enter = 0;
        tbufb_err = 0; tbufa_err = 0; pread_err = 0; obuf_err = 0; ibuf_err = 0;
        clr_ram_start = 0; clr_ram_done = 0;
    endtask

    task automatic hwrite(input logic [3:0] be, input logic [31:0] d);
        host_we = 1; host_be = be; host_wdata = d;
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        tick(); tick();
        chk("R1 reset word", int'(host_rdata), 32'h80);
        rst_n = 1;
        tick();
        chk("R1 word after release", int'(host_rdata), 32'h80);

        // R9: sequencer model finishes the reset clear after a few cycles
        for (int k = 0; k < 4; k++) tick();
        clr_ram_done = 1; tick();
        chk("R9 busy cleared by done", int'(host_rdata[7]), 0);

        // R2: updates and transmits
        upd_valid = 1; upd_idx = 7'h55; tick();
        chk("R2 update loads", int'(host_rdata[30:24]), 32'h55);
        tx_valid = 1; tx_idx = 7'h7F; upd_valid = 1; upd_idx = 7'h01; tick();
        chk("R2 transmit loads", int'(host_rdata[22:16]), 32'h7F);

        // R3: state change clears both
        cfg_exit = 1; tick();
        chk("R3 cfg exit clears", int'(host_rdata[30:16]), 0);
        upd_valid = 1; upd_idx = 7'h33; tx_valid = 1; tx_idx = 7'h22; tick();
        startup_enter = 1; upd_valid = 1; upd_idx = 7'h44; tick();
        chk("R3 update beats clear", int'(host_rdata[30:24]), 32'h44);
        chk("R3 tx cleared", int'(host_rdata[22:16]), 0);

        // R4: host writes to upper lanes have no effect
        tx_valid = 1; tx_idx = 7'h12; tick();
        hwrite(4'b1110, 32'hFFFF_FFFF);
        chk("R4 upper write ignored", int'(host_rdata[30:8]), int'({7'h44, 1'b0, 7'h12, 1'b0, 7'h00}));

        // R5/R6: fault capture and lock
        fault_valid = 1; fault_idx = 7'h2A; tick();
        chk("R5 first fault index", int'(host_rdata[14:8]), 32'h2A);
        chk("R5 detect set", int'(host_rdata[5]), 1);
        fault_valid = 1; fault_idx = 7'h11; tick();
        chk("R5 index frozen", int'(host_rdata[14:8]), 32'h2A);
        chk("R6 multi set", int'(host_rdata[6]), 1);

        // R7: write 0 and lane-off writes are ignored
        hwrite(4'b0001, 32'h0);
        hwrite(4'b1110, 32'hFF);
        chk("R7 no clear without lane", int'(host_rdata[6:5]), 3);
        // R8: fault with clear in the same cycle keeps detect set
        fault_valid = 1; fault_idx = 7'h05; host_we = 1; host_be = 4'b0001; host_wdata = 32'h20; tick();
        chk("R8 detect survives clear", int'(host_rdata[5]), 1);
        hwrite(4'b0001, 32'h60);
        chk("R7 detect and multi cleared", int'(host_rdata[6:5]), 0);
        fault_valid = 1; fault_idx = 7'h09; tick();
        chk("R5 relock new index", int'(host_rdata[14:8]), 32'h09);
        chk("R6 multi stays clear", int'(host_rdata[6]), 0);

        // R11/R10: path flags
        tbufb_err = 1; tick();
        tbufa_err = 1; tick();
        pread_err = 1; obuf_err = 1; tick();
        ibuf_err = 1; tick();
        chk("R11 path flags set", int'(host_rdata[4:0]), 32'h1F);
        hwrite(4'b0001, 32'h0000_0012);
        chk("R10 R7 obuf kept, tbufb cleared", int'(host_rdata[4:0]), 32'h0F);
        tbufa_err = 1; host_we = 1; host_be = 4'b0001; host_wdata = 32'h08; tick();
        chk("R8 tbufa survives clear", int'(host_rdata[3]), 1);
        hwrite(4'b0001, 32'hFF);
        chk("R7 R10 all clearable gone", int'(host_rdata[7:0]), 32'h02);

        // R9: start, start with done, host write
        clr_ram_start = 1; tick();
        chk("R9 start sets busy", int'(host_rdata[7]), 1);
        hwrite(4'b1111, 32'h0000_0080);
        chk("R9 host cannot clear busy", int'(host_rdata[7]), 1);
        clr_ram_start = 1; clr_ram_done = 1; tick();
        chk("R9 start beats done", int'(host_rdata[7]), 1);
        for (int k = 0; k < 3; k++) tick();
        clr_ram_done = 1; tick();
        chk("R9 done clears", int'(host_rdata[7]), 0);

        // R1: reset again mid-run
        rst_n = 0; tick();
        chk("R1 reset restores word", int'(host_rdata), 32'h80);
        rst_n = 1; tick();

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule